// File: doc/BRIEF.md
# Enclave-Aware Branch Trace Recorder

This block keeps a circular stack of the most recent control transfers as from/to address pairs, and raises a one-cycle branch-step trap pulse. The core hands it at most one event per cycle: an ordinary taken branch, a fresh enclave entry, an enclave resume, an enclave exit, or an asynchronous enclave exit. Every event carries an opt-in flag, the instruction address, the destination address, the resume address held in the state save area, and the asynchronous exit landing pointer.

The recorder picks the address pair that fits the event kind. It writes the pair into the next slot of a 16-entry ring and moves the top-of-stack pointer. It also tracks whether execution is inside an enclave and whether that enclave opted in to debug. Branches inside an opted-out enclave leave no trace and raise no trap. Software can read any slot through a read port with one cycle of latency.

Top module: `branch_trace_rec`

## Requirements
- R1: After reset the top-of-stack index is DEPTH-1 (15). Every slot reads back as zero, the trap output is low, and execution counts as outside any enclave.
- R2: A fresh entry (kind code 2) or a resume (kind code 3) with recording enabled writes the pair {instruction address, destination address}. This happens whatever the opt-in flag is.
- R3: An enclave exit (kind code 4) with recording enabled writes the pair {instruction address, destination address}.
- R4: An asynchronous exit (kind code 5) with recording enabled writes the pair {saved resume address, exit landing pointer}.
- R5: A taken branch (kind code 1) with recording enabled writes {instruction address, destination address} when outside an enclave or inside an opted-in one. Inside an opted-out enclave it writes nothing and the index does not move.
- R6: With the recording enable low, no event writes a slot or moves the index. Mode tracking and the trap still work.
- R7: With the step enable high, the trap output pulses high for exactly the cycle after a fresh entry whose opt-in flag is 1, and the cycle after an enclave exit.
- R8: A resume (either opt-in value), an asynchronous exit, a fresh entry with opt-in flag 0, and any event while the step enable is low never raise the trap.
- R9: With the step enable high, a taken branch raises the trap in the next cycle when outside an enclave or inside an opted-in enclave. Inside an opted-out enclave it does not.
- R10: Each write goes to slot (index+1) mod DEPTH, and that value becomes the new index, so the 17th write overwrites the slot of the 1st. The index output changes in the cycle after the event.
- R11: The read port returns the pair stored at the requested slot in the cycle after the request. The value is the content before any write made in the same cycle.
- R12: Fresh entry and resume set the enclave mode, taking the opt-in flag from the event. Exit and asynchronous exit clear it. Kind codes 0, 6 and 7 have no effect on anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_kind | input | 3 | Event kind: 0 none, 1 branch, 2 fresh entry, 3 resume, 4 exit, 5 async exit |
| ev_opt_in | input | 1 | Opt-in flag of the entered enclave |
| ev_insn_addr | input | ADDR_W | Address of the transferring instruction |
| ev_dest_addr | input | ADDR_W | Destination of the transfer |
| ev_ssa_rip | input | ADDR_W | Resume address saved in the state save area |
| ev_aex_ptr | input | ADDR_W | Landing pointer after an asynchronous exit |
| rec_en | input | 1 | Recording enable |
| step_en | input | 1 | Branch single-step enable |
| rd_idx | input | IDX_W | Slot to read |
| tos | output | IDX_W | Index of the most recent record |
| step_trap | output | 1 | Single-step trap pulse |
| rd_from | output | ADDR_W | From-address of the read slot |
| rd_to | output | ADDR_W | To-address of the read slot |

## Verification
Every event kind is driven from each enclave mode: outside, opted in and opted out. This shows that the choice of address pair and the trap decision follow both the event kind and the tracked mode. The two enables are toggled on their own, so that gated records and gated traps can be told apart. A run of more than sixteen branches wraps the ring while the read index sweeps all slots every cycle. This tells overwrite order apart from stale or same-cycle read data. Reserved kind codes check that unused encodings leave the state untouched.

// File: rtl/brt_pkg.sv
package brt_pkg;
    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_BRANCH = 3'd1,
        EV_ENTER  = 3'd2,
        EV_RESUME = 3'd3,
        EV_EXIT   = 3'd4,
        EV_AEX    = 3'd5
    } ev_kind_e;

    typedef struct packed {
        logic in_encl;
        logic opt_in;
    } mode_t;
endpackage

// File: rtl/brt_event_decode.sv
module brt_event_decode #(
    parameter int ADDR_W = 48
) (
    input  logic [2:0]        ev_kind,
    input  logic              ev_opt_in,
    input  logic [ADDR_W-1:0] ev_insn_addr,
    input  logic [ADDR_W-1:0] ev_dest_addr,
    input  logic [ADDR_W-1:0] ev_ssa_rip,
    input  logic [ADDR_W-1:0] ev_aex_ptr,
    input  logic              rec_en,
    input  logic              step_en,
    input  brt_pkg::mode_t    mode,
    output logic              push,
    output logic [ADDR_W-1:0] rec_from,
    output logic [ADDR_W-1:0] rec_to,
    output logic              trap,
    output logic              mode_set,
    output logic              mode_clr,
    output logic              mode_opt
);
    import brt_pkg::*;

    logic branch_visible;

    always_comb begin
        branch_visible = !mode.in_encl || mode.opt_in;
        push     = 1'b0;
        trap     = 1'b0;
        mode_set = 1'b0;
        mode_clr = 1'b0;
        mode_opt = 1'b0;
        rec_from = ev_insn_addr;
        rec_to   = ev_dest_addr;
        case (ev_kind)
            EV_BRANCH: begin
                push = rec_en && branch_visible;
                trap = step_en && branch_visible;
            end
            EV_ENTER: begin
                push     = rec_en;
                trap     = step_en && ev_opt_in;
                mode_set = 1'b1;
                mode_opt = ev_opt_in;
            end
            EV_RESUME: begin
                push     = rec_en;
                mode_set = 1'b1;
                mode_opt = ev_opt_in;
            end
            EV_EXIT: begin
                push     = rec_en;
                trap     = step_en;
                mode_clr = 1'b1;
            end
            EV_AEX: begin
                push     = rec_en;
                rec_from = ev_ssa_rip;
                rec_to   = ev_aex_ptr;
                mode_clr = 1'b1;
            end
            default: begin
                push = 1'b0;
            end
        endcase
    end

    always_comb begin
        a_r6_push_gated: assert (!push || rec_en);
        a_r8_trap_gated: assert (!trap || step_en);
    end
endmodule

// File: rtl/brt_mode_track.sv
module brt_mode_track (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_set,
    input  logic           mode_clr,
    input  logic           mode_opt,
    output brt_pkg::mode_t mode
);
    import brt_pkg::*;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (mode_set) begin
            mode_d.in_encl = 1'b1;
            mode_d.opt_in  = mode_opt;
        end else if (mode_clr) begin
            mode_d.in_encl = 1'b0;
            mode_d.opt_in  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    a_r12_clear_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clr && !mode_set) |=> !mode_q.in_encl);
    a_r12_set_enters: assert property (@(posedge clk) disable iff (!rst_n)
        mode_set |=> (mode_q.in_encl && mode_q.opt_in == $past(mode_opt)));
endmodule

// File: rtl/brt_stack.sv
module brt_stack #(
    parameter int ADDR_W = 48,
    parameter int DEPTH  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_from,
    input  logic [ADDR_W-1:0] push_to,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  tos,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0]             tos;
        logic [DEPTH-1:0][ADDR_W-1:0] from;
        logic [DEPTH-1:0][ADDR_W-1:0] to;
        logic [ADDR_W-1:0]            rd_from;
        logic [ADDR_W-1:0]            rd_to;
    } stack_t;

    stack_t s_d, s_q;
    logic [IDX_W-1:0] next_slot;

    always_comb begin
        next_slot = (s_q.tos == LAST) ? '0 : s_q.tos + 1'b1;
        s_d = s_q;
        if (push) begin
            s_d.tos             = next_slot;
            s_d.from[next_slot] = push_from;
            s_d.to[next_slot]   = push_to;
        end
        if (int'(rd_idx) < DEPTH) begin
            s_d.rd_from = s_q.from[rd_idx];
            s_d.rd_to   = s_q.to[rd_idx];
        end else begin
            s_d.rd_from = '0;
            s_d.rd_to   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.tos <= LAST;
        end else begin
            s_q <= s_d;
        end
    end

    assign tos     = s_q.tos;
    assign rd_from = s_q.rd_from;
    assign rd_to   = s_q.rd_to;

    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && tos == LAST) |=> (tos == '0));
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(tos));
endmodule

// File: rtl/branch_trace_rec.sv
module branch_trace_rec #(
    parameter int ADDR_W = 48,
    parameter int DEPTH  = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ev_kind,
    input  logic              ev_opt_in,
    input  logic [ADDR_W-1:0] ev_insn_addr,
    input  logic [ADDR_W-1:0] ev_dest_addr,
    input  logic [ADDR_W-1:0] ev_ssa_rip,
    input  logic [ADDR_W-1:0] ev_aex_ptr,
    input  logic              rec_en,
    input  logic              step_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  tos,
    output logic              step_trap,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to
);
    import brt_pkg::*;

    mode_t             mode;
    logic              push_w, trap_w;
    logic              set_w, clr_w, opt_w;
    logic [ADDR_W-1:0] from_w, to_w;

    typedef struct packed {
        logic trap;
    } top_t;

    top_t t_d, t_q;

    brt_event_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ev_kind      (ev_kind),
        .ev_opt_in    (ev_opt_in),
        .ev_insn_addr (ev_insn_addr),
        .ev_dest_addr (ev_dest_addr),
        .ev_ssa_rip   (ev_ssa_rip),
        .ev_aex_ptr   (ev_aex_ptr),
        .rec_en       (rec_en),
        .step_en      (step_en),
        .mode         (mode),
        .push         (push_w),
        .rec_from     (from_w),
        .rec_to       (to_w),
        .trap         (trap_w),
        .mode_set     (set_w),
        .mode_clr     (clr_w),
        .mode_opt     (opt_w)
    );

    brt_mode_track u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_set (set_w),
        .mode_clr (clr_w),
        .mode_opt (opt_w),
        .mode     (mode)
    );

    brt_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_w),
        .push_from (from_w),
        .push_to   (to_w),
        .rd_idx    (rd_idx),
        .tos       (tos),
        .rd_from   (rd_from),
        .rd_to     (rd_to)
    );

    always_comb begin
        t_d      = t_q;
        t_d.trap = trap_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign step_trap = t_q.trap;

    a_r6_rec_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(tos));
    a_r7_trap_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        step_trap |-> $past(step_en));
    a_r8_quiet_kinds: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == EV_RESUME || ev_kind == EV_AEX) |=> !step_trap);
    a_r9_optout_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_kind == EV_BRANCH && mode.in_encl && !mode.opt_in) |=> (!step_trap && $stable(tos)));
endmodule

// File: tb/branch_trace_rec_tb.sv
module branch_trace_rec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 48;
    localparam int DP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    ev_kind = '0;
    logic          ev_opt_in = 1'b0;
    logic [AW-1:0] ev_insn_addr = '0, ev_dest_addr = '0, ev_ssa_rip = '0, ev_aex_ptr = '0;
    logic          rec_en = 1'b1, step_en = 1'b1;
    logic [3:0]    rd_idx = '0;
    logic [3:0]    tos;
    logic          step_trap;
    logic [AW-1:0] rd_from, rd_to;

    int checks = 0, errors = 0, seq = 0, rptr = 0;
    bit done = 0;

    logic [AW-1:0] mfrom [DP];
    logic [AW-1:0] mto   [DP];
    int  mtos = DP - 1;
    bit  m_in = 0, m_opt = 0, m_trap = 0;
    logic [AW-1:0] m_rdf = '0, m_rdt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_trace_rec u_dut (
        .clk(clk), .rst_n(rst_n), .ev_kind(ev_kind), .ev_opt_in(ev_opt_in),
        .ev_insn_addr(ev_insn_addr), .ev_dest_addr(ev_dest_addr),
        .ev_ssa_rip(ev_ssa_rip), .ev_aex_ptr(ev_aex_ptr),
        .rec_en(rec_en), .step_en(step_en), .rd_idx(rd_idx),
        .tos(tos), .step_trap(step_trap), .rd_from(rd_from), .rd_to(rd_to)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of one event, applied at the clock edge.
    task automatic model(input int k, input bit opt);
        bit do_push, visible;
        m_rdf = mfrom[rd_idx];
        m_rdt = mto[rd_idx];
        visible = !m_in || m_opt;
        do_push = 0;
        m_trap = 0;
        if (k == 1) begin do_push = visible; m_trap = step_en && visible; end
        if (k == 2) begin do_push = 1; m_trap = step_en && opt; end
        if (k == 3) do_push = 1;
        if (k == 4) begin do_push = 1; m_trap = step_en; end
        if (k == 5) do_push = 1;
        if (do_push && rec_en) begin
            mtos = (mtos + 1) % DP;
            mfrom[mtos] = (k == 5) ? ev_ssa_rip : ev_insn_addr;
            mto[mtos]   = (k == 5) ? ev_aex_ptr : ev_dest_addr;
        end
        if (k == 2 || k == 3) begin m_in = 1; m_opt = opt; end
        if (k == 4 || k == 5) begin m_in = 0; m_opt = 0; end
    endtask

    task automatic step(input int k, input bit opt, input string tag);
        seq++;
        ev_kind      = 3'(k);
        ev_opt_in    = opt;
        ev_insn_addr = {16'h1000, 32'(seq)};
        ev_dest_addr = {16'h2000, 32'(seq)};
        ev_ssa_rip   = {16'h3000, 32'(seq)};
        ev_aex_ptr   = {16'h4000, 32'(seq)};
        rd_idx       = 4'(rptr);
        rptr++;
        @(posedge clk);
        model(k, opt);
        @(negedge clk);
        chk(tos == 4'(mtos), {tag, " R10 tos"}, 64'(tos), 64'(mtos));
        chk(step_trap == m_trap, {tag, " trap"}, 64'(step_trap), 64'(m_trap));
        chk(rd_from == m_rdf, {tag, " R11 rd_from"}, 64'(rd_from), 64'(m_rdf));
        chk(rd_to == m_rdt, {tag, " R11 rd_to"}, 64'(rd_to), 64'(m_rdt));
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DP; i++) begin mfrom[i] = '0; mto[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(tos == 4'(DP - 1), "R1 reset tos", 64'(tos), 64'(DP - 1));
        chk(step_trap == 1'b0, "R1 reset trap", 64'(step_trap), 0);
        for (int i = 0; i < DP; i++) step(0, 0, "R1 empty read");

        step(1, 0, "R5 R9 branch outside");
        step(2, 1, "R2 R7 optin enter");
        step(1, 0, "R5 R9 optin branch");
        step(1, 0, "R5 R9 optin branch");
        step(4, 0, "R3 R7 exit");
        step(0, 0, "R7 pulse ends");
        step(2, 0, "R2 R8 optout enter");
        step(1, 0, "R5 R9 optout branch");
        step(1, 0, "R5 R9 optout branch");
        step(5, 0, "R4 R8 aex");
        step(3, 1, "R2 R8 resume optin");
        step(1, 0, "R12 branch after resume");
        step(5, 0, "R4 R8 aex");
        step(3, 0, "R2 R8 resume optout");
        step(1, 0, "R12 branch suppressed");
        step(4, 0, "R3 exit");
        step(6, 1, "R12 reserved");
        step(7, 0, "R12 reserved");

        rec_en = 1'b0;
        step(1, 0, "R6 branch no rec");
        step(2, 1, "R6 R7 enter no rec");
        step(4, 0, "R6 exit no rec");
        rec_en = 1'b1;
        step_en = 1'b0;
        step(1, 0, "R8 no step");
        step(2, 1, "R8 enter no step");
        step(4, 0, "R8 exit no step");
        step_en = 1'b1;

        for (int i = 0; i < 20; i++) step(1, 0, "R10 wrap");
        for (int i = 0; i < DP; i++) step(0, 0, "R11 sweep");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule